// File: doc/BRIEF.md
# DRAM Strobe-Order Cycle Decoder

This block is the memory-side control logic of an asynchronous DRAM. It watches the row strobe, the column strobe and the write enable, all active low, and works out what kind of cycle the controller started. It does this from the levels the column strobe and write enable hold when the row strobe falls. The strobes are brought into the system clock domain through a two-flop synchronizer. Every decision is reported as a one-clock event with a cycle type and a row. There are five possible results: a normal read or write access, a row-address-only refresh, a refresh that takes its row from an internal counter, a hidden refresh, and entry into a parallel test mode.

The test mode is a latch. A refresh cycle of any kind clears it. While it is set, a read does not return the bit chosen by column bit 0. It returns, for each data lane, whether the two internal bits of that lane agree. On a normal read the selected bit is driven onto the lane. An early write leaves the lanes in high impedance.

The decoder produces no data stream. `cyc_valid` is a one-clock strobe with no ready signal, so there is no back-pressure: each event must be consumed in the clock in which it is shown.

Top module: `dram_cycle_decoder`

## Requirements
- R1: While reset is held and immediately after it is released, `cyc_valid`, `test_mode` and `dq_oe` are 0, and the internal refresh counter is 0.
- R2: Every cycle event appears on `cyc_valid`/`cyc_type`/`cyc_row` exactly three clocks after the strobe change that decides it. It lasts one clock. Type codes: 1 read, 2 write, 3 address-only refresh, 4 counter refresh, 5 hidden refresh, 6 test entry.
- R3: If the column strobe is high when the row strobe falls and the column strobe then falls, the cycle is an access. Write enable low at that column fall gives type 2 with `dq_oe` 0. Write enable high gives type 1.
- R4: On a normal read, `dq_out[i]` equals `rd_bits[2*i + c]`, where c is address bit 0 sampled at the column fall. `dq_oe` is 1 from the read event until the column strobe rises.
- R5: If the row strobe falls and rises again with no column fall in between, the event is type 3 and `cyc_row` is the address sampled at the row fall.
- R6: Column strobe low and write enable high at the row fall gives type 4. `cyc_row` is the counter value, and the counter then advances by one.
- R7: The refresh counter is ROW_W bits wide and wraps from all ones to zero.
- R8: Column strobe and write enable both low at the row fall gives type 6. `test_mode` becomes 1, `cyc_row` shows the counter, and the counter does not advance.
- R9: `test_mode` stays set across accesses. Events of type 3, 4 and 5 clear it, and it changes only together with an event.
- R10: On a read in test mode, `dq_out[i]` is 1 exactly when `rd_bits[2*i]` equals `rd_bits[2*i+1]`. Address bit 0 has no effect.
- R11: If the column strobe stays low after a read while the row strobe rises and falls again, the event is type 5. It refreshes the counter row like type 4, and `dq_out` and `dq_oe` keep the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | ROW_W | Multiplexed row/column address |
| rd_bits | input | 2*DQ_W | Internal read bits, two per lane |
| cyc_valid | output | 1 | One-clock cycle event strobe |
| cyc_type | output | 3 | Decoded cycle type code |
| cyc_row | output | ROW_W | Row of the decoded cycle |
| test_mode | output | 1 | Test mode latch |
| dq_out | output | DQ_W | Read data or compressed test result |
| dq_oe | output | 1 | Lane drive enable |

## Verification
Every result depends on a strobe edge crossing the two synchronizer flops and one output register. The event, `cyc_row`, `test_mode`, `dq_out` and `dq_oe` therefore all change at the third rising clock edge after the input moves. The bench changes inputs on falling edges and holds each strobe level for five clocks, so every decision settles before the next stimulus. A clock-by-clock reference model repeats the three-clock delay with plain integer history. All outputs are compared with it on every falling edge. Scenario checks then read back the last captured event, and the lane values while the column strobe is still low.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  typedef enum logic [2:0] {
    CYC_NONE   = 3'd0,
    CYC_READ   = 3'd1,
    CYC_WRITE  = 3'd2,
    CYC_RASREF = 3'd3,
    CYC_CBR    = 3'd4,
    CYC_HIDDEN = 3'd5,
    CYC_TEST   = 3'd6
  } cyc_e;
endpackage

// File: rtl/dcd_sync.sv
module dcd_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[g] <= '1;
      else if (g == 0) st[g] <= d;
      else st[g] <= st[(g == 0) ? 0 : g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/dcd_edge.sv
module dcd_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] fall,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else prev <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_det
    assign fall[i] = prev[i] & ~lvl[i];
    assign rise[i] = ~prev[i] & lvl[i];
  end
endmodule

// File: rtl/dcd_refcnt.sv
module dcd_refcnt #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [ROW_W-1:0] cnt
);
  localparam logic [ROW_W-1:0] ONE = ROW_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (step) cnt <= cnt + ONE;
  end
endmodule

// File: rtl/dcd_dqsel.sv
module dcd_dqsel #(
  parameter int DQ_W = 4
) (
  input  logic [2*DQ_W-1:0] bits,
  input  logic              col0,
  input  logic              tmode,
  output logic [DQ_W-1:0]   dq
);
  for (genvar i = 0; i < DQ_W; i++) begin : g_lane
    logic lo, hi;
    assign lo = bits[2*i];
    assign hi = bits[2*i+1];
    assign dq[i] = tmode ? ~(lo ^ hi) : (col0 ? hi : lo);
  end
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import dcd_pkg::*;
#(
  parameter int ROW_W    = 10,
  parameter int DQ_W     = 4,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ROW_W-1:0]  addr,
  input  logic [2*DQ_W-1:0] rd_bits,
  output logic              cyc_valid,
  output logic [2:0]        cyc_type,
  output logic [ROW_W-1:0]  cyc_row,
  output logic              test_mode,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe
);
  localparam int NSTB = 3;

  logic [NSTB-1:0] stb_lvl;
  logic [1:0]      stb_fall, stb_rise;
  logic            ras_l, cas_l, we_l;
  logic            ras_fall, ras_rise, cas_fall, cas_rise;
  logic [ROW_W-1:0] ref_cnt, row_lat;
  logic            cnt_step;
  logic [DQ_W-1:0] dq_next;
  logic            pend, hold;
  cyc_e            typ_q;

  dcd_sync #(.W(NSTB), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({we_n, cas_n, ras_n}), .q(stb_lvl)
  );

  assign ras_l = stb_lvl[0];
  assign cas_l = stb_lvl[1];
  assign we_l  = stb_lvl[2];

  dcd_edge #(.W(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(stb_lvl[1:0]),
    .fall(stb_fall), .rise(stb_rise)
  );

  assign ras_fall = stb_fall[0];
  assign ras_rise = stb_rise[0];
  assign cas_fall = stb_fall[1];
  assign cas_rise = stb_rise[1];

  // counter advances on counter-sourced refreshes only (not test entry)
  assign cnt_step = ras_fall & ~cas_l & we_l;

  dcd_refcnt #(.ROW_W(ROW_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(cnt_step), .cnt(ref_cnt)
  );

  dcd_dqsel #(.DQ_W(DQ_W)) u_dq (
    .bits(rd_bits), .col0(addr[0]), .tmode(test_mode), .dq(dq_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_valid <= 1'b0;
      typ_q     <= CYC_NONE;
      cyc_row   <= '0;
      test_mode <= 1'b0;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
      pend      <= 1'b0;
      hold      <= 1'b0;
      row_lat   <= '0;
    end else begin
      cyc_valid <= 1'b0;
      if (ras_fall) begin
        if (!cas_l) begin
          cyc_valid <= 1'b1;
          cyc_row   <= ref_cnt;
          if (!we_l) begin
            typ_q     <= CYC_TEST;
            test_mode <= 1'b1;
          end else begin
            typ_q     <= hold ? CYC_HIDDEN : CYC_CBR;
            test_mode <= 1'b0;
          end
        end else begin
          pend    <= 1'b1;
          row_lat <= addr;
        end
      end else if (pend && cas_fall) begin
        pend      <= 1'b0;
        cyc_valid <= 1'b1;
        cyc_row   <= row_lat;
        if (!we_l) begin
          typ_q <= CYC_WRITE;
          dq_oe <= 1'b0;
          hold  <= 1'b0;
        end else begin
          typ_q  <= CYC_READ;
          dq_out <= dq_next;
          dq_oe  <= 1'b1;
          hold   <= 1'b1;
        end
      end else if (pend && ras_rise) begin
        pend      <= 1'b0;
        cyc_valid <= 1'b1;
        cyc_row   <= row_lat;
        typ_q     <= CYC_RASREF;
        test_mode <= 1'b0;
      end
      if (cas_rise) begin
        dq_oe <= 1'b0;
        hold  <= 1'b0;
      end
    end
  end

  assign cyc_type = typ_q;
endmodule

// File: rtl/dcd_checker.sv
module dcd_checker #(
  parameter int ROW_W = 10,
  parameter int DQ_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_valid,
  input logic [2:0]       cyc_type,
  input logic [ROW_W-1:0] cyc_row,
  input logic             test_mode,
  input logic [DQ_W-1:0]  dq_out,
  input logic             dq_oe,
  input logic [ROW_W-1:0] ref_cnt
);
  // R1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (!cyc_valid && !test_mode && !dq_oe && ref_cnt == '0);
    end
  end

  // R8
  tm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type == 3'd6) |-> test_mode);

  // R9
  tm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && (cyc_type == 3'd3 || cyc_type == 3'd4 || cyc_type == 3'd5)) |-> !test_mode);

  // R9
  tm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(test_mode) |-> cyc_valid);

  // R3
  write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type == 3'd2) |-> !dq_oe);

  // R4
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type == 3'd1) |-> dq_oe);

  // R11
  hidden_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type == 3'd5) |-> ($stable(dq_out) && $stable(dq_oe) && dq_oe));

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && (cyc_type == 3'd4 || cyc_type == 3'd5)) |-> ref_cnt == ROW_W'(cyc_row + 1'b1));

  // R8
  cnt_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type == 3'd6) |-> ref_cnt == cyc_row);
endmodule

bind dram_cycle_decoder dcd_checker #(.ROW_W(ROW_W), .DQ_W(DQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_type(cyc_type),
  .cyc_row(cyc_row), .test_mode(test_mode), .dq_out(dq_out),
  .dq_oe(dq_oe), .ref_cnt(ref_cnt)
);

// File: tb/dram_cycle_decoder_test.sv
module dram_cycle_decoder_test;
  localparam int ROW_W = 10;
  localparam int DQ_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [ROW_W-1:0]  addr = '0;
  logic [2*DQ_W-1:0] rd_bits = '0;
  logic              cyc_valid, test_mode, dq_oe;
  logic [2:0]        cyc_type;
  logic [ROW_W-1:0]  cyc_row;
  logic [DQ_W-1:0]   dq_out;

  int n_chk = 0, n_fail = 0, cycles = 0;
  int last_type = 0, last_row = -1;

  always #4 clk = ~clk;

  dram_cycle_decoder uut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .rd_bits(rd_bits), .cyc_valid(cyc_valid), .cyc_type(cyc_type),
    .cyc_row(cyc_row), .test_mode(test_mode), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: plain integer history of the strobes, three-clock delay
  int mr1 = 1, mr2 = 1, mrd = 1, mc1 = 1, mc2 = 1, mcd = 1, mw1 = 1, mw2 = 1;
  int e_cnt = 0, e_pend = 0, e_hold = 0, e_lat = 0;
  int e_valid = 0, e_type = 0, e_row = 0, e_tm = 0, e_oe = 0;
  logic [DQ_W-1:0] e_dq = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mr1 = 1; mr2 = 1; mrd = 1; mc1 = 1; mc2 = 1; mcd = 1; mw1 = 1; mw2 = 1;
      e_cnt = 0; e_pend = 0; e_hold = 0; e_lat = 0;
      e_valid = 0; e_type = 0; e_row = 0; e_tm = 0; e_oe = 0; e_dq = '0;
    end else begin
      bit rf, rr, cf, cr;
      rf = (mrd == 1 && mr2 == 0);
      rr = (mrd == 0 && mr2 == 1);
      cf = (mcd == 1 && mc2 == 0);
      cr = (mcd == 0 && mc2 == 1);
      e_valid = 0;
      if (rf) begin
        if (mc2 == 0) begin
          e_valid = 1; e_row = e_cnt;
          if (mw2 == 0) begin e_type = 6; e_tm = 1; end
          else begin
            e_type = e_hold ? 5 : 4; e_tm = 0;
            e_cnt = (e_cnt + 1) % (1 << ROW_W);
          end
        end else begin
          e_pend = 1; e_lat = int'(addr);
        end
      end else if (e_pend && cf) begin
        e_pend = 0; e_valid = 1; e_row = e_lat;
        if (mw2 == 0) begin e_type = 2; e_oe = 0; e_hold = 0; end
        else begin
          e_type = 1; e_oe = 1; e_hold = 1;
          for (int i = 0; i < DQ_W; i++)
            e_dq[i] = e_tm ? (rd_bits[2*i] == rd_bits[2*i+1]) : rd_bits[2*i + int'(addr[0])];
        end
      end else if (e_pend && rr) begin
        e_pend = 0; e_valid = 1; e_row = e_lat; e_type = 3; e_tm = 0;
      end
      if (cr) begin e_oe = 0; e_hold = 0; end
      mrd = mr2; mr2 = mr1; mr1 = int'(ras_n);
      mcd = mc2; mc2 = mc1; mc1 = int'(cas_n);
      mw2 = mw1; mw1 = int'(we_n);
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(int'(cyc_valid) == e_valid, "R2 valid", int'(cyc_valid), e_valid);
      if (e_valid != 0) begin
        chk(int'(cyc_type) == e_type, "R2 type", int'(cyc_type), e_type);
        chk(int'(cyc_row) == e_row, "R5/R6 row", int'(cyc_row), e_row);
      end
      chk(int'(test_mode) == e_tm, "R9 test_mode", int'(test_mode), e_tm);
      chk(int'(dq_oe) == e_oe, "R4 dq_oe", int'(dq_oe), e_oe);
      if (e_oe != 0) chk(dq_out == e_dq, "R4/R10 dq_out", int'(dq_out), int'(e_dq));
      if (cyc_valid) begin last_type = int'(cyc_type); last_row = int'(cyc_row); end
    end
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic hold5(); repeat (5) @(negedge clk); endtask
  task automatic set_ras(input logic v); ras_n = v; hold5(); endtask
  task automatic set_cas(input logic v); cas_n = v; hold5(); endtask

  task automatic cbr_cycle();
    set_cas(1'b0); set_ras(1'b0); set_ras(1'b1); set_cas(1'b1);
  endtask

  task automatic test_entry();
    we_n = 1'b0; set_cas(1'b0); set_ras(1'b0); set_ras(1'b1);
    set_cas(1'b1); we_n = 1'b1; hold5();
  endtask

  task automatic ras_only(input int row);
    addr = ROW_W'(row); set_ras(1'b0); set_ras(1'b1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!cyc_valid && !test_mode && !dq_oe, "R1 reset idle",
        int'({cyc_valid, test_mode, dq_oe}), 0);
    rst_n = 1'b1;
    hold5();
    chk(!cyc_valid && !test_mode && !dq_oe, "R1 after release",
        int'({cyc_valid, test_mode, dq_oe}), 0);

    // R5: address-only refresh
    ras_only(341);
    chk(last_type == 3, "R5 type", last_type, 3);
    chk(last_row == 341, "R5 row", last_row, 341);

    // R2: event exactly three clocks after the row strobe moves
    addr = ROW_W'(77); ras_n = 1'b0;
    @(negedge clk); @(negedge clk);
    ras_n = 1'b1;
    @(negedge clk);
    chk(!cyc_valid, "R2 not early", int'(cyc_valid), 0);
    @(negedge clk); @(negedge clk);
    chk(cyc_valid && cyc_type == 3'd3, "R2 on time", int'(cyc_valid), 1);
    hold5();

    // R3/R4: normal read, column bit 0 = 0 then 1
    addr = ROW_W'(5); set_ras(1'b0);
    addr = ROW_W'(0); rd_bits = 8'hB2; set_cas(1'b0);
    chk(last_type == 1, "R3 read type", last_type, 1);
    chk(dq_oe && dq_out == 4'h4, "R4 read col0", int'(dq_out), 4);
    set_cas(1'b1);
    chk(!dq_oe, "R4 oe off", int'(dq_oe), 0);
    addr = ROW_W'(1); set_cas(1'b0);
    chk(dq_out == 4'h4, "R4 page cas ignored w/o new row", int'(dq_out), 4);
    set_cas(1'b1); set_ras(1'b1);
    addr = ROW_W'(6); set_ras(1'b0);
    addr = ROW_W'(1); set_cas(1'b0);
    chk(dq_oe && dq_out == 4'hD, "R4 read col1", int'(dq_out), 13);
    chk(last_row == 6, "R3 row", last_row, 6);
    set_cas(1'b1); set_ras(1'b1);

    // R3: early write
    addr = ROW_W'(9); set_ras(1'b0);
    we_n = 1'b0; set_cas(1'b0);
    chk(last_type == 2 && !dq_oe, "R3 write", last_type, 2);
    set_cas(1'b1); we_n = 1'b1; set_ras(1'b1);

    // R6: counter refresh rows 0 and 1
    cbr_cycle();
    chk(last_type == 4 && last_row == 0, "R6 first", last_row, 0);
    cbr_cycle();
    chk(last_row == 1, "R6 second", last_row, 1);

    // R8: test entry, counter not advanced
    test_entry();
    chk(last_type == 6, "R8 type", last_type, 6);
    chk(last_row == 2, "R8 counter held", last_row, 2);
    chk(test_mode, "R8 latched", int'(test_mode), 1);

    // R10/R9: compressed reads, col bit 0 ignored, mode persists
    addr = ROW_W'(3); set_ras(1'b0);
    addr = ROW_W'(0); rd_bits = 8'hB2; set_cas(1'b0);
    chk(dq_out == 4'h6, "R10 col0", int'(dq_out), 6);
    set_cas(1'b1); set_ras(1'b1);
    addr = ROW_W'(3); set_ras(1'b0);
    addr = ROW_W'(1); set_cas(1'b0);
    chk(dq_out == 4'h6, "R10 col1", int'(dq_out), 6);
    set_cas(1'b1); set_ras(1'b1);
    chk(test_mode, "R9 persists", int'(test_mode), 1);

    // R9: cleared by address-only refresh, then by counter refresh
    ras_only(12);
    chk(!test_mode, "R9 cleared by ras-only", int'(test_mode), 0);
    test_entry();
    cbr_cycle();
    chk(!test_mode && last_row == 2, "R9 cleared by cbr", last_row, 2);

    // R11: hidden refresh after a read
    addr = ROW_W'(7); set_ras(1'b0);
    addr = ROW_W'(1); rd_bits = 8'hB2; set_cas(1'b0);
    set_ras(1'b1); set_ras(1'b0);
    chk(last_type == 5, "R11 type", last_type, 5);
    chk(last_row == 3, "R11 row", last_row, 3);
    chk(dq_oe && dq_out == 4'hD, "R11 data kept", int'(dq_out), 13);
    set_ras(1'b1); set_cas(1'b1);

    // R7: counter wraps (now at 4)
    for (int k = 4; k < 1024; k++) cbr_cycle();
    chk(last_row == 1023, "R7 top row", last_row, 1023);
    cbr_cycle();
    chk(last_row == 0, "R7 wrap", last_row, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule